// File: doc/BRIEF.md
# Modulus Down-Counter with Sticky Underflow Flag

This block holds a down-counter of configurable width (16 bits by default) and a bus-visible flag register. Software writes a start value into the count register. That value is also kept as the modulus for later reloads. While the counter runs, each prescaled enable tick lowers the count by one. The tick that takes the count to zero sets a sticky underflow flag, and the flag can drive an interrupt line.

When the count sits at zero, the next tick either reloads the modulus (wrap mode) or leaves the counter parked at zero. The flag is cleared by writing a one to its bit. When the chip-wide fast-clear input is high, any read or write of the count register also clears the flag. The block does not contain the prescaler or an interrupt controller.

Top module: `modcnt_top`

## Requirements
- R1: After a synchronous active-low reset, the count, the modulus, the control register and the flag are all 0, and `irq` is 0.
- R2: A write to address 1 (count register) loads `bus_wdata` into both the count and the modulus. A read of address 1 returns the current count. A write in the same cycle as a tick takes priority over the tick.
- R3: While control bit 2 (run) is 1, each cycle with `tick` high and a nonzero count lowers the count by exactly one. With run at 0 or `tick` low, the count holds.
- R4: The flag (address 2, bit 0) becomes 1 on the cycle after a tick takes the count from 1 to 0. It then stays 1 until it is cleared.
- R5: A running tick that finds the count at 0 reloads the modulus when control bit 1 (wrap) is 1. It leaves the count at 0 when wrap is 0. Neither case sets the flag.
- R6: A write to address 2 with `bus_wdata[0]`=1 clears the flag. With bit 0 at 0 the write leaves the flag unchanged. Bits above bit 0 of address 2 read as 0.
- R7: While `fclr_en` is 1, any read or write of address 1 clears the flag. While `fclr_en` is 0, such an access leaves the flag unchanged.
- R8: `irq` is 1 exactly when the flag is 1 and control bit 0 (interrupt enable) is 1.
- R9: If a set event (R4) and a clear (R6 or R7) fall in the same cycle, the flag ends up 1.
- R10: Address 0 is the control register. Bits [2:0] are written from `bus_wdata` and read back, the remaining bits read 0, and address 3 reads 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tick | input | 1 | Prescaled count enable, one cycle per step |
| fclr_en | input | 1 | Chip-wide fast-clear enable |
| bus_sel | input | 1 | Register access select |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_addr | input | 2 | Register address |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Read data, combinational on address |
| irq | output | 1 | Underflow interrupt |

## Verification
The bench builds the block with an 8-bit counter. Random loads drawn from small values then reach zero within a few ticks. This makes underflow, wrap reload, the zero-modulus case and holding at zero occur many times per run, along with collisions between a set event and a clear. Directed sequences force the remaining orderings: a set alongside a write-one clear, a set alongside a fast-clear read, a write racing a tick, and accesses with fast-clear off.

// File: rtl/modcnt_pkg.sv
// Package modcnt_pkg
// Shared register addresses and the control-register layout for the
// modulus down-counter. Assumes a two-bit register address space.
package modcnt_pkg;

    localparam int ADDR_W = 2;
    localparam int CTRL_W = 3;

    typedef enum logic [ADDR_W-1:0] {
        RA_CTRL  = 2'd0,
        RA_COUNT = 2'd1,
        RA_FLAG  = 2'd2,
        RA_SPARE = 2'd3
    } reg_addr_e;

    // bit 2 run, bit 1 wrap, bit 0 interrupt enable
    typedef struct packed {
        logic run;
        logic wrap;
        logic irq_en;
    } ctrl_t;

endpackage

// File: rtl/modcnt_regs.sv
// Module modcnt_regs
// Bus decode, control register and read-data multiplexer.
// Assumes single-cycle accesses qualified by bus_sel; read data is
// combinational on the address; DATA_W is at least CTRL_W.
module modcnt_regs #(
    parameter int DATA_W = 16,
    parameter int CNT_W  = 16
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          bus_sel,
    input  logic                          bus_wr,
    input  logic                          bus_rd,
    input  logic [modcnt_pkg::ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0]             bus_wdata,
    input  logic [CNT_W-1:0]              cnt_val,
    input  logic                          flag_val,
    output modcnt_pkg::ctrl_t             ctrl,
    output logic                          cnt_load,
    output logic                          cnt_access,
    output logic                          flag_w1c,
    output logic [DATA_W-1:0]             bus_rdata
);
    import modcnt_pkg::*;

    localparam int PAD_W = DATA_W - CTRL_W;

    reg_addr_e addr;
    logic      any_access;
    logic      ctrl_wr;

    // Decode each strobe into per-register requests.
    always_comb begin
        addr       = reg_addr_e'(bus_addr);
        any_access = bus_sel && (bus_wr || bus_rd);
        ctrl_wr    = bus_sel && bus_wr && (addr == RA_CTRL);
        cnt_load   = bus_sel && bus_wr && (addr == RA_COUNT);
        cnt_access = any_access && (addr == RA_COUNT);
        flag_w1c   = bus_sel && bus_wr && (addr == RA_FLAG) && bus_wdata[0];
    end

    // Hold the control bits written at the control address.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl <= '0;
        end else if (ctrl_wr) begin
            ctrl <= ctrl_t'(bus_wdata[CTRL_W-1:0]);
        end
    end

    logic [DATA_W-1:0] ctrl_word;
    logic [DATA_W-1:0] cnt_word;

    // Widen the control bits to the bus width (variant chosen by width).
    generate
        if (PAD_W > 0) begin : g_ctrl_pad
            assign ctrl_word = {{PAD_W{1'b0}}, ctrl};
        end else begin : g_ctrl_exact
            assign ctrl_word = ctrl;
        end
        if (DATA_W > CNT_W) begin : g_cnt_pad
            assign cnt_word = {{(DATA_W-CNT_W){1'b0}}, cnt_val};
        end else begin : g_cnt_trunc
            assign cnt_word = cnt_val[DATA_W-1:0];
        end
    endgenerate

    // Select read data by address; unused bits read as zero.
    always_comb begin
        unique case (addr)
            RA_CTRL:  bus_rdata = ctrl_word;
            RA_COUNT: bus_rdata = cnt_word;
            RA_FLAG:  bus_rdata = {{(DATA_W-1){1'b0}}, flag_val};
            default:  bus_rdata = '0;
        endcase
    end

    // A control write shows its low bits on the next cycle (R10).
    p_ctrl_wr_r10: assert property (@(posedge clk) disable iff (!rst_n)
        ctrl_wr |=> (ctrl == ctrl_t'($past(bus_wdata[CTRL_W-1:0]))));

    // Without a control write the control bits stay put (R10).
    p_ctrl_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !ctrl_wr |=> $stable(ctrl));

endmodule

// File: rtl/modcnt_counter.sv
// Module modcnt_counter
// Down-counter with modulus register, reload and zero detection.
// Assumes tick is a one-cycle enable. A bus load beats a tick in the
// same cycle. set_evt is high when a tick moves the count from 1 to 0.
module modcnt_counter #(
    parameter int CNT_W  = 16,
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic              run,
    input  logic              wrap,
    input  logic              load,
    input  logic [DATA_W-1:0] load_val,
    output logic [CNT_W-1:0]  cnt,
    output logic              set_evt
);
    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    logic [CNT_W-1:0] modv;
    logic [CNT_W-1:0] load_cnt;
    logic             step;
    logic             at_zero;

    // Fit the bus word to the counter width.
    generate
        if (DATA_W >= CNT_W) begin : g_load_trunc
            assign load_cnt = load_val[CNT_W-1:0];
        end else begin : g_load_pad
            assign load_cnt = {{(CNT_W-DATA_W){1'b0}}, load_val};
        end
    endgenerate

    // Qualify a counting step and flag the 1-to-0 transition.
    always_comb begin
        step    = run && tick && !load;
        at_zero = (cnt == '0);
        set_evt = step && (cnt == ONE);
    end

    // Keep the modulus written by the bus.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            modv <= '0;
        end else if (load) begin
            modv <= load_cnt;
        end
    end

    // Load, decrement, reload or hold the count.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (load) begin
            cnt <= load_cnt;
        end else if (step) begin
            if (!at_zero) begin
                cnt <= cnt - ONE;
            end else if (wrap) begin
                cnt <= modv;
            end
        end
    end

    p_load_r2: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> (cnt == $past(load_cnt)));

    p_dec_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (run && tick && !load && cnt != '0) |=> (cnt == $past(cnt) - ONE));

    p_idle_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!load && !(run && tick)) |=> $stable(cnt));

    p_reload_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (run && tick && !load && cnt == '0 && wrap) |=> (cnt == $past(modv)));

    p_park_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (run && tick && !load && cnt == '0 && !wrap) |=> (cnt == '0));

endmodule

// File: rtl/modcnt_flag.sv
// Module modcnt_flag
// Sticky underflow flag with write-one clear, fast clear and the
// interrupt output. Assumes the clear requests are already decoded.
// A set in the same cycle as a clear leaves the flag at one.
module modcnt_flag (
    input  logic clk,
    input  logic rst_n,
    input  logic set_evt,
    input  logic w1c_req,
    input  logic fclr_en,
    input  logic cnt_access,
    input  logic irq_en,
    output logic flag,
    output logic irq
);
    logic clr_req;

    // Merge the two clear sources.
    always_comb begin
        clr_req = w1c_req || (fclr_en && cnt_access);
    end

    // Set has priority over clear.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flag <= 1'b0;
        end else if (set_evt) begin
            flag <= 1'b1;
        end else if (clr_req) begin
            flag <= 1'b0;
        end
    end

    // Gate the flag with the interrupt enable.
    always_comb begin
        irq = flag && irq_en;
    end

    p_set_r4: assert property (@(posedge clk) disable iff (!rst_n)
        set_evt |=> flag);

    p_sticky_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (!w1c_req && !(fclr_en && cnt_access) && flag) |=> flag);

    p_w1c_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (w1c_req && !set_evt) |=> !flag);

    p_fast_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (fclr_en && cnt_access && !set_evt) |=> !flag);

    p_noset_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (!set_evt && !flag) |=> !flag);

endmodule

// File: rtl/modcnt_top.sv
// Module modcnt_top
// Modulus down-counter with a sticky underflow flag behind a small
// register interface. Assumes tick comes from an external prescaler and
// fclr_en from a chip-wide control bit.
module modcnt_top #(
    parameter int CNT_W  = 16,
    parameter int DATA_W = 16
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          tick,
    input  logic                          fclr_en,
    input  logic                          bus_sel,
    input  logic                          bus_wr,
    input  logic                          bus_rd,
    input  logic [modcnt_pkg::ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0]             bus_wdata,
    output logic [DATA_W-1:0]             bus_rdata,
    output logic                          irq
);
    import modcnt_pkg::*;

    ctrl_t            ctrl;
    logic             cnt_load;
    logic             cnt_access;
    logic             flag_w1c;
    logic [CNT_W-1:0] cnt;
    logic             set_evt;
    logic             flag;

    modcnt_regs #(.DATA_W(DATA_W), .CNT_W(CNT_W)) u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .bus_sel    (bus_sel),
        .bus_wr     (bus_wr),
        .bus_rd     (bus_rd),
        .bus_addr   (bus_addr),
        .bus_wdata  (bus_wdata),
        .cnt_val    (cnt),
        .flag_val   (flag),
        .ctrl       (ctrl),
        .cnt_load   (cnt_load),
        .cnt_access (cnt_access),
        .flag_w1c   (flag_w1c),
        .bus_rdata  (bus_rdata)
    );

    modcnt_counter #(.CNT_W(CNT_W), .DATA_W(DATA_W)) u_counter (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick     (tick),
        .run      (ctrl.run),
        .wrap     (ctrl.wrap),
        .load     (cnt_load),
        .load_val (bus_wdata),
        .cnt      (cnt),
        .set_evt  (set_evt)
    );

    modcnt_flag u_flag (
        .clk        (clk),
        .rst_n      (rst_n),
        .set_evt    (set_evt),
        .w1c_req    (flag_w1c),
        .fclr_en    (fclr_en),
        .cnt_access (cnt_access),
        .irq_en     (ctrl.irq_en),
        .flag       (flag),
        .irq        (irq)
    );

    // The cycle after reset releases, the interrupt is still low (R1).
    p_reset_quiet_r1: assert property (@(posedge clk)
        !rst_n |=> !irq);

endmodule

// File: tb/tb_modcnt_top.sv
module tb_modcnt_top;
    localparam int CLK_PERIOD = 10;
    localparam int W          = 8;
    localparam int N_RANDOM   = 6000;

    logic         clk = 1'b0;
    logic         rst_n;
    logic         tick, fclr_en, bus_sel, bus_wr, bus_rd;
    logic [1:0]   bus_addr;
    logic [W-1:0] bus_wdata;
    logic [W-1:0] bus_rdata;
    logic         irq;

    int n_checks = 0;
    int n_fail   = 0;

    // Reference state, kept by the bench from the requirements.
    logic [W-1:0] m_cnt, m_mod;
    logic [2:0]   m_ctrl;
    logic         m_flag;

    always #(CLK_PERIOD/2) clk = ~clk;

    modcnt_top #(.CNT_W(W), .DATA_W(W)) dut (
        .clk(clk), .rst_n(rst_n), .tick(tick), .fclr_en(fclr_en),
        .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .irq(irq)
    );

    function automatic logic [W-1:0] exp_read(input logic [1:0] a);
        case (a)
            2'd0:    return {{(W-3){1'b0}}, m_ctrl};
            2'd1:    return m_cnt;
            2'd2:    return {{(W-1){1'b0}}, m_flag};
            default: return '0;
        endcase
    endfunction

    function automatic logic exp_irq();
        return m_flag && m_ctrl[0];
    endfunction

    task automatic check(input logic [W-1:0] act, input logic [W-1:0] exp,
                         input string tag, input string what);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
        end
    endtask

    // Advance the reference by one clock from the inputs now applied.
    task automatic model_step();
        logic acc, load, cwr, w1c, fc, st, set;
        acc  = bus_sel && (bus_wr || bus_rd);
        load = bus_sel && bus_wr && bus_addr == 2'd1;
        cwr  = bus_sel && bus_wr && bus_addr == 2'd0;
        w1c  = bus_sel && bus_wr && bus_addr == 2'd2 && bus_wdata[0];
        fc   = fclr_en && acc && bus_addr == 2'd1;
        st   = m_ctrl[2] && tick && !load;
        set  = st && m_cnt == W'(1);
        if (load) begin
            m_cnt = bus_wdata;
            m_mod = bus_wdata;
        end else if (st) begin
            if (m_cnt != '0)    m_cnt = m_cnt - W'(1);
            else if (m_ctrl[1]) m_cnt = m_mod;
        end
        if (set)            m_flag = 1'b1;
        else if (w1c || fc) m_flag = 1'b0;
        if (cwr) m_ctrl = bus_wdata[2:0];
    endtask

    // Apply one cycle of inputs at a falling edge, compare, then clock.
    task automatic cycle(input logic s, input logic wr, input logic rd,
                         input logic [1:0] a, input logic [W-1:0] wd,
                         input logic tk, input logic fc, input string tag);
        bus_sel = s; bus_wr = wr; bus_rd = rd; bus_addr = a;
        bus_wdata = wd; tick = tk; fclr_en = fc;
        #1;
        check(bus_rdata, exp_read(a), tag, "rdata");
        check({{(W-1){1'b0}}, irq}, {{(W-1){1'b0}}, exp_irq()}, "R8", "irq");
        model_step();
        @(negedge clk);
    endtask

    task automatic idle(input string tag);
        cycle(1'b0, 1'b0, 1'b0, 2'd1, '0, 1'b0, 1'b0, tag);
    endtask

    task automatic wr(input logic [1:0] a, input logic [W-1:0] d, input string tag);
        cycle(1'b1, 1'b1, 1'b0, a, d, 1'b0, 1'b0, tag);
    endtask

    // Ends a hung run as a failure.
    initial begin
        #(CLK_PERIOD * 150000);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected finish");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
        $finish;
    end

    initial begin
        int seed;
        seed = 32'h5eed_c0de;
        void'($urandom(seed));
        m_cnt = '0; m_mod = '0; m_ctrl = '0; m_flag = 1'b0;
        rst_n = 1'b0;
        bus_sel = 0; bus_wr = 0; bus_rd = 0; bus_addr = 0; bus_wdata = 0;
        tick = 0; fclr_en = 0;
        repeat (3) @(negedge clk);
        // Stimulus the design must ignore while reset is held.
        bus_sel = 1; bus_wr = 1; bus_addr = 2'd1; bus_wdata = 8'h5a; tick = 1;
        @(negedge clk);
        rst_n = 1'b1;

        // R1: every register reads zero after reset, irq low.
        for (int a = 0; a < 4; a++) cycle(1'b0, 1'b0, 1'b0, 2'(a), '0, 1'b0, 1'b0, "R1");

        // R10: control readback and masking of upper bits.
        wr(2'd0, 8'hff, "R10");
        idle("R10");
        cycle(1'b1, 1'b0, 1'b1, 2'd0, '0, 1'b0, 1'b0, "R10");
        cycle(1'b1, 1'b0, 1'b1, 2'd3, '0, 1'b0, 1'b0, "R10");

        // R2/R3: load 3, tick down, idle holds, write beats tick.
        wr(2'd0, 8'h05, "R2");               // run, irq enable, no wrap
        wr(2'd1, 8'h03, "R2");
        cycle(1'b0, 1'b0, 1'b0, 2'd1, '0, 1'b1, 1'b0, "R3");
        idle("R3");
        cycle(1'b1, 1'b1, 1'b0, 2'd1, 8'h02, 1'b1, 1'b0, "R2");
        idle("R2");

        // R4/R5: count to zero, then park at zero without a new set.
        for (int i = 0; i < 4; i++) cycle(1'b0, 1'b0, 1'b0, 2'd2, '0, 1'b1, 1'b0, "R4");
        cycle(1'b0, 1'b0, 1'b0, 2'd1, '0, 1'b1, 1'b0, "R5");

        // R6: write zero keeps the flag, write one clears it.
        wr(2'd2, 8'hfe, "R6");
        idle("R6");
        wr(2'd2, 8'h01, "R6");
        cycle(1'b0, 1'b0, 1'b0, 2'd2, '0, 1'b0, 1'b0, "R6");

        // R5: wrap mode reloads the modulus after zero.
        wr(2'd0, 8'h07, "R5");
        wr(2'd1, 8'h02, "R5");
        for (int i = 0; i < 4; i++) cycle(1'b0, 1'b0, 1'b0, 2'd1, '0, 1'b1, 1'b0, "R5");

        // R7: count access with fast clear off keeps, with it on clears.
        cycle(1'b1, 1'b0, 1'b1, 2'd1, '0, 1'b0, 1'b0, "R7");
        cycle(1'b0, 1'b0, 1'b0, 2'd2, '0, 1'b0, 1'b0, "R7");
        cycle(1'b1, 1'b0, 1'b1, 2'd1, '0, 1'b0, 1'b1, "R7");
        cycle(1'b0, 1'b0, 1'b0, 2'd2, '0, 1'b0, 1'b0, "R7");
        wr(2'd1, 8'h01, "R7");
        cycle(1'b0, 1'b0, 1'b0, 2'd1, '0, 1'b1, 1'b0, "R7");  // underflow sets
        cycle(1'b1, 1'b1, 1'b0, 2'd1, 8'h04, 1'b0, 1'b1, "R7");
        cycle(1'b0, 1'b0, 1'b0, 2'd2, '0, 1'b0, 1'b0, "R7");

        // R9: set alongside a write-one clear, then alongside a fast-clear read.
        wr(2'd1, 8'h01, "R9");
        cycle(1'b1, 1'b1, 1'b0, 2'd2, 8'h01, 1'b1, 1'b0, "R9");
        cycle(1'b0, 1'b0, 1'b0, 2'd2, '0, 1'b0, 1'b0, "R9");
        wr(2'd2, 8'h01, "R9");
        wr(2'd1, 8'h01, "R9");
        cycle(1'b1, 1'b0, 1'b1, 2'd1, '0, 1'b1, 1'b1, "R9");
        cycle(1'b0, 1'b0, 1'b0, 2'd2, '0, 1'b0, 1'b0, "R9");

        // Random traffic with small loads so underflow recurs often.
        for (int i = 0; i < N_RANDOM; i++) begin
            logic s, w, r, tk, fc;
            logic [1:0] a;
            logic [W-1:0] d;
            s  = ($urandom % 4) == 0;
            w  = $urandom % 2;
            r  = $urandom % 2;
            a  = 2'($urandom % 4);
            d  = (a == 2'd0) ? W'(4 | ($urandom % 8)) :
                 (($urandom % 8) == 0 ? W'($urandom) : W'($urandom % 6));
            tk = ($urandom % 3) != 0;
            fc = $urandom % 2;
            cycle(s, w, r, a, d, tk, fc, (a == 2'd2) ? "R4" : "R3");
        end

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
        $finish;
    end
endmodule